// File: doc/BRIEF.md
# Shared-Setting Input Deglitch Filter

This block cleans up one raw input bit from a pad before the rest of the chip uses it. It keeps no filter parameters of its own. A 12-bit bus carries four shared filter settings, and a 2-bit per-pin selector chooses which of them the pin follows. Each setting holds a single-cycle sample strobe and a 2-bit length code. The strobe sets the sample interval and the code sets how many samples must agree.

Flops local to the pin hold an 8-bit sample history and the filtered level. The output moves to a new level only when every one of the most recent L samples shows that level. Any disagreement keeps the previous level. A per-pin bypass bit sends the raw input to the output with no filtering. Logic outside the block decides when each shared strobe fires.

Top module: `pin_deglitch`

## Requirements
- R1: Setting k (k = 0..3) occupies `set_bus[3k+2:3k]`. Bit 3k is its sample strobe and bits [3k+2:3k+1] are its length code. `pin_sel` = k selects setting k, and the other settings have no effect on the pin.
- R2: The length code sets the sample count L: 2'b00 gives L=2, 2'b01 gives L=3, 2'b10 gives L=5 and 2'b11 gives L=8.
- R3: A clock edge with the selected strobe high shifts `raw_in` into the newest end of the history. On an edge with the strobe low, neither the history nor `filt_out` changes, whatever `raw_in` does (unless bypass is set).
- R4: On a strobed edge with bypass clear, `filt_out` takes level v at that same edge if the newest L history bits, including the sample just taken, are all v.
- R5: On a strobed edge where the newest L samples disagree, `filt_out` keeps its previous value.
- R6: While `bypass` is 1, `filt_out` becomes the `raw_in` value of the previous edge at every edge. The history keeps sampling on strobes. After bypass clears, the output holds until an agreeing strobe.
- R7: `rst` is synchronous and active high. A reset edge fills all 8 history bits with `raw_in` and sets `filt_out` to `raw_in`.
- R8: A change of `pin_sel` leaves the history intact. The newly selected setting's next strobe samples and decides using the samples already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_bus | input | 12 | Four shared settings, 3 bits each: strobe and length code |
| pin_sel | input | 2 | Chooses which shared setting this pin follows |
| bypass | input | 1 | 1 sends the raw input to the output unfiltered |
| raw_in | input | 1 | Raw pad input bit |
| filt_out | output | 1 | Registered filtered input |

## Verification
The bench sweeps every selector value against every length code and several strobe spacings. While it does this, the unselected settings carry noise. A design that decoded the wrong field, or that let another setting's strobe through, therefore drifts away from the bench model. Exact boundary runs place L-1 agreeing samples and then the L-th. An off-by-one length mask would switch one sample early or late. Another run changes the selector partway through a run of samples. A design that cleared the history on the change would need extra samples before switching. A further run toggles the input between strobes and under bypass, which exposes outputs that update without a strobe or that lag the raw input.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

  // One shared setting: length code above, strobe in bit 0.
  typedef struct packed {
    logic [1:0] len_code;
    logic       strobe;
  } dgf_setting_t;

  localparam int SETTING_W = $bits(dgf_setting_t);

  // Sample count selected by a length code.
  function automatic logic [3:0] code_to_len(input logic [1:0] code);
    case (code)
      2'b00:   code_to_len = 4'd2;
      2'b01:   code_to_len = 4'd3;
      2'b10:   code_to_len = 4'd5;
      default: code_to_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dgf_setting_mux.sv
module dgf_setting_mux
  import dgf_pkg::*;
#(
  parameter int N_SET = 4,
  localparam int SEL_W = $clog2(N_SET),
  localparam int BUS_W = N_SET * SETTING_W
) (
  input  logic [BUS_W-1:0] set_bus,
  input  logic [SEL_W-1:0] pin_sel,
  output logic             strobe,
  output logic [1:0]       len_code
);

  dgf_setting_t setting [N_SET];

  // Unpack the shared bus into one struct per setting (R1).
  for (genvar k = 0; k < N_SET; k++) begin : g_unpack
    assign setting[k] = set_bus[k*SETTING_W +: SETTING_W];
  end

  dgf_setting_t chosen;
  always_comb begin
    chosen   = setting[pin_sel];
    strobe   = chosen.strobe;
    len_code = chosen.len_code;
  end

endmodule

// File: rtl/dgf_history.sv
module dgf_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_in,
  input  logic              strobe,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] hist_d
);

  // Next history value: the newest sample enters at bit 0.
  always_comb begin
    if (rst)         hist_d = {HIST_W{raw_in}};
    else if (strobe) hist_d = {hist_q[HIST_W-2:0], raw_in};
    else             hist_d = hist_q;
  end

  always_ff @(posedge clk) begin
    hist_q <= hist_d;
  end

  // R3: no strobe means the history holds.
  a_r3_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(hist_q));

  // R3: a strobe captures the raw input at the newest position.
  a_r3_hist_shift: assert property (@(posedge clk) disable iff (rst)
    strobe |=> hist_q[0] == $past(raw_in));

endmodule

// File: rtl/dgf_decide.sv
module dgf_decide
  import dgf_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_in,
  input  logic              bypass,
  input  logic              strobe,
  input  logic [1:0]        len_code,
  input  logic [HIST_W-1:0] hist_d,
  output logic              out_q
);

  logic [HIST_W-1:0] len_mask;
  logic              all_ones;
  logic              all_zeros;

  // Mask covering the newest L samples (R2).
  always_comb begin
    for (int i = 0; i < HIST_W; i++) begin
      len_mask[i] = (i < int'(code_to_len(len_code)));
    end
    all_ones  = ((hist_d & len_mask) == len_mask);
    all_zeros = ((hist_d & len_mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= raw_in;
    end else if (bypass) begin
      out_q <= raw_in;
    end else if (strobe) begin
      if (all_ones)       out_q <= 1'b1;
      else if (all_zeros) out_q <= 1'b0;
    end
  end

  // R3 / R5: the filtered level cannot move without a strobe.
  a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !bypass) |=> $stable(out_q));

  // R4: any change of level is preceded by a strobe, bypass or reset.
  a_r4_change_cause: assert property (@(posedge clk) disable iff (rst)
    (out_q != $past(out_q)) |-> $past(strobe || bypass || rst));

endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
  import dgf_pkg::*;
#(
  parameter int N_SET  = 4,
  parameter int HIST_W = 8,
  localparam int SEL_W = $clog2(N_SET),
  localparam int BUS_W = N_SET * SETTING_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] set_bus,
  input  logic [SEL_W-1:0] pin_sel,
  input  logic             bypass,
  input  logic             raw_in,
  output logic             filt_out
);

  logic              strobe;
  logic [1:0]        len_code;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  dgf_setting_mux #(.N_SET(N_SET)) u_mux (
    .set_bus  (set_bus),
    .pin_sel  (pin_sel),
    .strobe   (strobe),
    .len_code (len_code)
  );

  dgf_history #(.HIST_W(HIST_W)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .raw_in (raw_in),
    .strobe (strobe),
    .hist_q (hist_q),
    .hist_d (hist_d)
  );

  dgf_decide #(.HIST_W(HIST_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .raw_in   (raw_in),
    .bypass   (bypass),
    .strobe   (strobe),
    .len_code (len_code),
    .hist_d   (hist_d),
    .out_q    (filt_out)
  );

  // R6: bypass makes the output follow the raw input one edge later.
  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    bypass |=> filt_out == $past(raw_in));

  // R7: a reset edge loads the raw input into the output.
  a_r7_reset: assert property (@(posedge clk)
    rst |=> filt_out == $past(raw_in));

endmodule

// File: tb/sim_pin_deglitch.sv
`timescale 1ns/1ps
module sim_pin_deglitch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] set_bus = '0;
  logic [1:0]  pin_sel = '0;
  logic        bypass = 1'b0;
  logic        raw_in = 1'b0;
  logic        filt_out;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  logic [7:0]  m_hist = '0;
  logic        m_out  = 1'b0;
  logic [15:0] lfsr   = 16'hACE1;

  always #2.5 clk = ~clk;

  pin_deglitch u0 (
    .clk      (clk),
    .rst      (rst),
    .set_bus  (set_bus),
    .pin_sel  (pin_sel),
    .bypass   (bypass),
    .raw_in   (raw_in),
    .filt_out (filt_out)
  );

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'b00) ? 2 : (c == 2'b01) ? 3 : (c == 2'b10) ? 5 : 8;
  endfunction

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Apply the current inputs for one edge, update the model, compare.
  task automatic step(input string tag);
    logic       en;
    logic [1:0] code;
    logic [7:0] msk;
    en   = set_bus[3*pin_sel];
    code = set_bus[3*pin_sel+1 +: 2];
    msk  = 8'((16'd1 << len_of(code)) - 1);
    if (rst) begin
      m_hist = {8{raw_in}};
      m_out  = raw_in;
    end else begin
      if (en) m_hist = {m_hist[6:0], raw_in};
      if (bypass) m_out = raw_in;
      else if (en && ((m_hist & msk) == msk)) m_out = 1'b1;
      else if (en && ((m_hist & msk) == 8'h00)) m_out = 1'b0;
    end
    @(posedge clk);
    #1;
    n_vec++;
    if (filt_out !== m_out) begin
      n_bad++;
      $display("FAIL %s at %0t: filt_out=%b expected %b", tag, $time, filt_out, m_out);
    end
  endtask

  task automatic expect_lvl(input string tag, input logic exp);
    n_vec++;
    if (filt_out !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: filt_out=%b expected %b", tag, $time, filt_out, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: finished=0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state with raw high, then low.
    raw_in = 1'b1; rst = 1'b1;
    step("R7 reset loads raw 1");
    expect_lvl("R7 reset level 1", 1'b1);
    raw_in = 1'b0;
    step("R7 reset loads raw 0");
    expect_lvl("R7 reset level 0", 1'b0);
    rst = 1'b0;

    // R1 R2 R4 R5: sweep every select, code and strobe spacing with noise elsewhere.
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int per = 1; per <= 3; per++) begin
          pin_sel = 2'(s);
          for (int t = 0; t < 60; t++) begin
            rnd();
            set_bus = lfsr[11:0];
            set_bus[3*s]      = ((t % per) == 0);
            set_bus[3*s+1 +: 2] = 2'(c);
            if (per == 2) raw_in = lfsr[13];
            else if (lfsr[15:14] == 2'b00) raw_in = ~raw_in;
            step("R1 R2 R4 R5 sweep");
          end
        end
      end
    end

    // R3: input toggles with the selected strobe low; output must not move.
    pin_sel = 2'd3;
    set_bus = 12'b000_111_111_111;
    for (int t = 0; t < 12; t++) begin
      raw_in = ~raw_in;
      step("R3 no strobe hold");
    end

    // R4 R5: exact L=5 boundary on setting 2 (code 2'b10, strobe always).
    rst = 1'b1; raw_in = 1'b0; step("R7 reset before boundary");
    rst = 1'b0;
    pin_sel = 2'd2;
    set_bus = 12'b000_101_000_000;
    raw_in  = 1'b1;
    for (int t = 0; t < 4; t++) step("R5 four of five agree");
    expect_lvl("R5 L=5 not yet switched", 1'b0);
    step("R4 fifth sample");
    expect_lvl("R4 L=5 switches on fifth", 1'b1);
    raw_in = 1'b0; step("R5 single disagree");
    raw_in = 1'b1; step("R5 back to one");
    expect_lvl("R5 holds through glitch", 1'b1);

    // R8: select change keeps history.
    rst = 1'b1; raw_in = 1'b0; step("R7 reset before select test");
    rst = 1'b0;
    pin_sel = 2'd0;
    set_bus = 12'b000_000_000_111;
    raw_in  = 1'b1;
    for (int t = 0; t < 3; t++) step("R8 samples on setting 0");
    pin_sel = 2'd1;
    for (int t = 0; t < 10; t++) step("R8 new setting idle");
    expect_lvl("R8 idle after switch", 1'b0);
    set_bus = 12'b000_000_001_111;
    step("R8 first strobe of new setting");
    expect_lvl("R8 history kept, switches at once", 1'b1);

    // R6: bypass follows raw, then holds once released.
    set_bus = 12'b000_000_000_000;
    bypass  = 1'b1;
    for (int t = 0; t < 10; t++) begin
      rnd();
      raw_in = lfsr[0];
      step("R6 bypass follows raw");
    end
    raw_in = 1'b0; step("R6 bypass last");
    expect_lvl("R6 bypass level", 1'b0);
    bypass = 1'b0; raw_in = 1'b1;
    for (int t = 0; t < 4; t++) step("R6 release holds");
    expect_lvl("R6 held after release", 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule